// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block turns a 32-bit virtual address into a physical address using two on-chip tables. The first table, the segment map, is indexed by the current context together with the virtual segment field (address bits from 18 upward). It yields a page-group number. That number, joined with the page field (bits 17:12), indexes the second table. The second table holds 32-bit page entries. Each entry carries a valid flag, a write-permission flag, a supervisor-only flag, a non-cacheable flag, a two-bit space type, used and modified flags, a must-be-zero field and a page frame number. Pages are 4 KB in size.

Each translation is a fixed three-stage walk behind a valid/ready handshake. The first stage reads the segment map. The second stage reads the page entry. The third stage checks the entry, writes back the used and modified flags on success, and registers the response. The response carries the physical address, a cache-bypass flag and a one-hot fault code. A separate table-access port lets software load and read back either table directly. It is served only while no translation is in progress, and it takes priority over a new request in that state.

The default build implements 3 context bits, 6 segment-index bits (address bits 23:18), 4 page-group bits and 16 frame-number bits. The address-hole rule is written for the implemented segment width: every address bit from 31 down to the top implemented segment bit must have the same value. With a full 12-bit segment field this becomes the rule that bits 31:29 are all zeros or all ones.

Top module: `mmu_xlate`

## Requirements
- R1: An address is a hole when bits 31 down to 23 of the virtual address are not all equal. A hole returns fault code 3'b001 and changes no table entry.
- R2: The segment map is indexed by {context, va[23:18]}. The same virtual address used in different contexts reaches the page-group number stored for each context.
- R3: The page table is indexed by {page-group, va[17:12]}.
- R4: On success the physical address is {4'b0, frame[15:0], va[11:0]}, where frame is page-entry bits 15:0.
- R5: A page entry whose valid bit (bit 31) is clear returns fault code 3'b010.
- R6: A write to an entry whose write bit (bit 30) is clear returns the protection fault 3'b100.
- R7: A user access (req_user=1) to an entry whose supervisor-only bit (bit 29) is set returns 3'b100.
- R8: Only the first failing check sets the fault: hole, then invalid, then protection. The fault code is never more than one-hot, and 3'b000 means success.
- R9: rsp_nc is set on a successful access to an entry whose bit 28 is set.
- R10: A successful read sets bit 25 (used) in the stored entry. A successful write also sets bit 24 (modified). No other bit of the entry changes.
- R11: A faulting access leaves the stored page entry unchanged.
- R12: If a request is accepted in cycle k, rsp_valid is high for exactly one cycle, in cycle k+4. req_ready is low in cycles k+1 to k+3.
- R13: Table port: cfg_sel=0 selects the segment map (data bits 3:0) and cfg_sel=1 selects the page table. A read returns cfg_rdata with cfg_rvalid one cycle later. req_ready is low while cfg_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| req_ctx | input | 3 | Current context |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 32 | Physical address (meaningful only without a fault) |
| rsp_nc | output | 1 | Access must bypass the cache |
| rsp_fault | output | 3 | One-hot fault: bit0 hole, bit1 invalid, bit2 protection |
| cfg_en | input | 1 | Table access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 1 | 0 = segment map, 1 = page table |
| cfg_idx | input | 10 | Table index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data |
| cfg_rvalid | output | 1 | Read data valid |

## Verification
The same virtual address is translated under two contexts to confirm that the context really selects the segment entry. The page index is shown to pick the entry by using a neighbouring page that is invalid. Each check is tried in isolation: supervisor against user, write against read, and valid against invalid. Entries that fail several checks at once show the precedence order. Hole patterns include one that only the implemented-width rule catches, and one high address in the all-ones half that must translate. Read-back through the table port afterwards shows the difference between the used-only update after reads, the used-and-modified update after writes, and no update after any fault.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 12;
    localparam int PG_W     = 6;
    localparam int SEG_LSB  = OFF_W + PG_W;
    localparam int FRAME_W  = 16;

    typedef struct packed {
        logic        valid;
        logic        wr_ok;
        logic        sup_only;
        logic        no_cache;
        logic [1:0]  space;
        logic        used;
        logic        modified;
        logic [4:0]  zero_f;
        logic [2:0]  frame_hi;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'b000,
        FLT_HOLE    = 3'b001,
        FLT_INVALID = 3'b010,
        FLT_PROT    = 3'b100
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEG,
        ST_PTE,
        ST_WB
    } walk_st_e;

    function automatic logic all_same(input logic [VA_W-1:0] v, input int msb_lo);
        logic ones;
        logic zeros;
        ones  = 1'b1;
        zeros = 1'b1;
        for (int i = 0; i < VA_W; i++) begin
            if (i >= msb_lo) begin
                ones  = ones & v[i];
                zeros = zeros & ~v[i];
            end
        end
        return ones | zeros;
    endfunction

endpackage

// File: rtl/mmu_tbl_ram.sv
module mmu_tbl_ram #(
    parameter int W  = 32,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/mmu_pte_eval.sv
module mmu_pte_eval
    import mmu_pkg::*;
(
    input  pte_t               pte,
    input  logic               hole,
    input  logic               is_write,
    input  logic               is_user,
    input  logic [OFF_W-1:0]   off,
    output fault_e             fault,
    output logic               nc,
    output logic [VA_W-1:0]    pa,
    output pte_t               pte_upd
);
    localparam int PAD_W = VA_W - FRAME_W - OFF_W;

    always_comb begin
        if (hole) begin
            fault = FLT_HOLE;
        end else if (!pte.valid) begin
            fault = FLT_INVALID;
        end else if ((is_write && !pte.wr_ok) || (is_user && pte.sup_only)) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end

        pte_upd          = pte;
        pte_upd.used     = 1'b1;
        pte_upd.modified = pte.modified | is_write;

        nc = (fault == FLT_NONE) && pte.no_cache;
        pa = (fault == FLT_NONE) ? {{PAD_W{1'b0}}, pte.frame, off} : '0;
    end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int CTX_W     = 3,
    parameter int SEG_IDX_W = 6,
    parameter int GRP_W     = 4,
    localparam int SEG_AW   = CTX_W + SEG_IDX_W,
    localparam int PT_AW    = GRP_W + PG_W,
    localparam int CFG_AW   = (SEG_AW > PT_AW) ? SEG_AW : PT_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_pa,
    output logic              rsp_nc,
    output logic [2:0]        rsp_fault,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CFG_AW-1:0] cfg_idx,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_rvalid
);
    localparam int HOLE_LO = SEG_LSB + SEG_IDX_W - 1;

    walk_st_e            state;
    logic                busy;
    logic [SEG_AW-1:0]   seg_idx_q;
    logic [PG_W-1:0]     pg_q;
    logic [OFF_W-1:0]    off_q;
    logic                wr_q, usr_q, hole_q;
    logic [PT_AW-1:0]    pt_idx_q;
    logic                cfg_sel_q;

    logic                cfg_go;
    logic                seg_en, seg_we;
    logic [SEG_AW-1:0]   seg_addr;
    logic [GRP_W-1:0]    seg_rd;
    logic                pt_en, pt_we;
    logic [PT_AW-1:0]    pt_addr;
    logic [31:0]         pt_wd, pt_rd;

    pte_t                cur_pte, upd_pte;
    fault_e              fault;
    logic                nc;
    logic [VA_W-1:0]     pa;

    assign busy      = (state != ST_IDLE);
    assign cfg_go    = !busy && cfg_en;
    assign req_ready = !busy && !cfg_en;
    assign cur_pte   = pte_t'(pt_rd);

    mmu_pte_eval u_eval (
        .pte      (cur_pte),
        .hole     (hole_q),
        .is_write (wr_q),
        .is_user  (usr_q),
        .off      (off_q),
        .fault    (fault),
        .nc       (nc),
        .pa       (pa),
        .pte_upd  (upd_pte)
    );

    // Port steering: table access owns the tables while idle
    always_comb begin
        seg_en   = (cfg_go && !cfg_sel) || (state == ST_SEG);
        seg_we   = cfg_go && !cfg_sel && cfg_we;
        seg_addr = busy ? seg_idx_q : cfg_idx[SEG_AW-1:0];

        pt_en    = (cfg_go && cfg_sel) || (state == ST_PTE)
                   || ((state == ST_WB) && (fault == FLT_NONE));
        pt_we    = (cfg_go && cfg_sel && cfg_we)
                   || ((state == ST_WB) && (fault == FLT_NONE));
        if (state == ST_PTE) begin
            pt_addr = {seg_rd, pg_q};
        end else if (state == ST_WB) begin
            pt_addr = pt_idx_q;
        end else begin
            pt_addr = cfg_idx[PT_AW-1:0];
        end
        pt_wd    = busy ? 32'(upd_pte) : cfg_wdata;
    end

    mmu_tbl_ram #(.W(GRP_W), .AW(SEG_AW)) u_segmap (
        .clk   (clk),
        .en    (seg_en),
        .we    (seg_we),
        .addr  (seg_addr),
        .wdata (cfg_wdata[GRP_W-1:0]),
        .rdata (seg_rd)
    );

    mmu_tbl_ram #(.W(32), .AW(PT_AW)) u_ptable (
        .clk   (clk),
        .en    (pt_en),
        .we    (pt_we),
        .addr  (pt_addr),
        .wdata (pt_wd),
        .rdata (pt_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            rsp_valid  <= 1'b0;
            rsp_pa     <= '0;
            rsp_nc     <= 1'b0;
            rsp_fault  <= 3'b000;
            cfg_rvalid <= 1'b0;
            cfg_sel_q  <= 1'b0;
            seg_idx_q  <= '0;
            pg_q       <= '0;
            off_q      <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            hole_q     <= 1'b0;
            pt_idx_q   <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            cfg_rvalid <= cfg_go && !cfg_we;
            if (cfg_go) begin
                cfg_sel_q <= cfg_sel;
            end
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        seg_idx_q <= {req_ctx, req_va[SEG_LSB +: SEG_IDX_W]};
                        pg_q      <= req_va[OFF_W +: PG_W];
                        off_q     <= req_va[OFF_W-1:0];
                        wr_q      <= req_write;
                        usr_q     <= req_user;
                        hole_q    <= !all_same(req_va, HOLE_LO);
                        state     <= ST_SEG;
                    end
                end
                ST_SEG: state <= ST_PTE;
                ST_PTE: begin
                    pt_idx_q <= {seg_rd, pg_q};
                    state    <= ST_WB;
                end
                ST_WB: begin
                    rsp_valid <= 1'b1;
                    rsp_pa    <= pa;
                    rsp_nc    <= nc;
                    rsp_fault <= fault;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cfg_rdata = cfg_sel_q ? pt_rd : {{(32-GRP_W){1'b0}}, seg_rd};

endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
    import mmu_pkg::*;
#(
    parameter int SEG_IDX_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            rsp_valid,
    input logic [2:0]      rsp_fault,
    input logic            cfg_en,
    input logic            cfg_we,
    input logic            cfg_rvalid,
    input logic            busy
);
    localparam int HOLE_LO = SEG_LSB + SEG_IDX_W - 1;

    logic accept;
    logic va_hole;
    assign accept  = req_valid && req_ready;
    assign va_hole = !all_same(req_va, HOLE_LO);

    // R12
    walk_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R12
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##4 rsp_valid);

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8
    fault_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0(rsp_fault));

    // R1
    hole_fault_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(accept, 4) && $past(va_hole, 4)) |-> (rsp_valid && rsp_fault == 3'b001));

    // R13
    cfg_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !cfg_we && !busy) |=> cfg_rvalid);

    // R13
    cfg_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> !req_ready);
endmodule

bind mmu_xlate mmu_xlate_chk #(.SEG_IDX_W(SEG_IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_va     (req_va),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .cfg_en     (cfg_en),
    .cfg_we     (cfg_we),
    .cfg_rvalid (cfg_rvalid),
    .busy       (busy)
);

// File: tb/mmu_xlate_bench.sv
module mmu_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [2:0]  req_ctx = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_nc;
    logic [2:0]  rsp_fault;
    logic        cfg_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [9:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] pa;
        logic        nc;
        logic [2:0]  fault;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    logic [3:0]  sh_seg [512];
    logic [31:0] sh_pt  [1024];

    mmu_xlate u_mmu_xlate (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements
    function automatic exp_t model(input logic [31:0] va, input bit w, input bit u, input logic [2:0] ctx);
        exp_t e;
        logic [3:0]  g;
        logic [9:0]  pi;
        logic [31:0] p;
        e.pa = '0; e.nc = 1'b0;
        if (!((va[31:23] == 9'h000) || (va[31:23] == 9'h1FF))) begin
            e.fault = 3'b001;
            return e;
        end
        g  = sh_seg[{ctx, va[23:18]}];
        pi = {g, va[17:12]};
        p  = sh_pt[pi];
        if (!p[31])                     e.fault = 3'b010;
        else if ((w && !p[30]) || (u && p[29])) e.fault = 3'b100;
        else begin
            e.fault = 3'b000;
            e.pa = {4'b0, p[15:0], va[11:0]};
            e.nc = p[28];
            p[25] = 1'b1;
            if (w) p[24] = 1'b1;
            sh_pt[pi] = p;
        end
        return e;
    endfunction

    task automatic xlate(input logic [31:0] va, input bit w, input bit u, input logic [2:0] ctx, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e = model(va, w, u, ctx);
        e.cyc = cyc + 4;
        e.tag = tag;
        sbq.push_back(e);
        req_va = va; req_write = w; req_user = u; req_ctx = ctx; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input bit sel, input logic [9:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
        if (sel) sh_pt[idx] = d; else sh_seg[idx[8:0]] = d[3:0];
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input bit sel, input logic [9:0] idx, input string tag);
        logic [31:0] exp;
        exp = sel ? sh_pt[idx] : {28'b0, sh_seg[idx[8:0]]};
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_sel = sel; cfg_idx = idx;
        #1;
        chk(req_ready == 1'b0, "R13 ready low during table access", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
        cfg_en = 1'b0;
        chk(cfg_rvalid == 1'b1, "R13 rvalid", {31'b0, cfg_rvalid}, 32'h1);
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R12 unexpected response", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(cyc == e.cyc, {e.tag, " R12 latency"}, cyc, e.cyc);
                chk(rsp_fault == e.fault, {e.tag, " fault"}, {29'b0, rsp_fault}, {29'b0, e.fault});
                if (e.fault == 3'b000) begin
                    chk(rsp_pa == e.pa, {e.tag, " R4 pa"}, rsp_pa, e.pa);
                    chk(rsp_nc == e.nc, {e.tag, " R9 nc"}, {31'b0, rsp_nc}, {31'b0, e.nc});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "reset ready", {31'b0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk(cfg_rvalid == 1'b0, "reset cfg_rvalid", {31'b0, cfg_rvalid}, 32'h0);

        // Segment map: {ctx, seg}
        cfg_write(1'b0, {1'b0, 3'd0, 6'h01}, 32'h2);
        cfg_write(1'b0, {1'b0, 3'd1, 6'h01}, 32'h5);
        cfg_write(1'b0, {1'b0, 3'd0, 6'h00}, 32'h3);
        cfg_write(1'b0, {1'b0, 3'd0, 6'h21}, 32'h2);
        // Page table: {grp, page}
        cfg_write(1'b1, {4'd2, 6'd3}, 32'hC000_1234);  // valid, writable
        cfg_write(1'b1, {4'd5, 6'd3}, 32'hB000_BEEF);  // valid, sup-only, nc
        cfg_write(1'b1, {4'd2, 6'd4}, 32'h6000_0777);  // invalid
        cfg_write(1'b1, {4'd3, 6'd0}, 32'h8400_0042);  // valid, read-only, io

        cfg_read(1'b0, {1'b0, 3'd1, 6'h01}, "R13 segmap readback");
        cfg_read(1'b1, {4'd5, 6'd3}, "R13 ptable readback");

        xlate(32'h0004_3ABC, 0, 1, 3'd0, "R2 R3 user read ctx0");
        xlate(32'h0004_3ABC, 1, 0, 3'd0, "R10 write ctx0");
        xlate(32'h0004_3ABC, 0, 0, 3'd1, "R2 R9 sup read ctx1");
        xlate(32'h0004_3ABC, 0, 1, 3'd1, "R7 user on sup page");
        xlate(32'h0004_3ABC, 1, 0, 3'd1, "R6 write read-only");
        xlate(32'h0004_4123, 0, 0, 3'd0, "R3 R5 invalid page");
        xlate(32'h0004_4123, 1, 1, 3'd0, "R8 invalid beats prot");
        xlate(32'h4004_3ABC, 0, 0, 3'd0, "R1 hole top bits");
        xlate(32'h2004_4000, 1, 1, 3'd0, "R1 R8 hole beats invalid");
        xlate(32'h0084_3ABC, 0, 0, 3'd0, "R1 hole implemented width");
        xlate(32'hFF84_3FFF, 0, 0, 3'd0, "R1 high region ok");
        xlate(32'h0000_0010, 1, 0, 3'd0, "R6 R11 write ro page");
        xlate(32'h0000_0FF0, 0, 1, 3'd0, "R10 read ro page");
        drain();

        cfg_read(1'b1, {4'd2, 6'd3}, "R10 used+modified after write");
        cfg_read(1'b1, {4'd5, 6'd3}, "R10 R11 used only, no change on faults");
        cfg_read(1'b1, {4'd2, 6'd4}, "R11 invalid entry untouched");
        cfg_read(1'b1, {4'd3, 6'd0}, "R10 read sets used only");
        chk(sh_pt[{4'd2, 6'd3}] == 32'hC300_1234, "R10 model write bits", sh_pt[{4'd2, 6'd3}], 32'hC300_1234);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule